// File: doc/BRIEF.md
# Software-Filled Address Translation Buffer

This block is a small fully associative translation buffer whose contents are placed there only by software. Software stages a new mapping in a few registers. It writes the virtual page number, a valid flag and an address-space tag into a page register. It then writes protection, guarded, size and segment-valid bits into a segment register. Last, it writes the real page number. That final write is the trigger. It merges the three staged values into one entry, stores it at the slot named by a slot field in a control register, and moves that slot field on.

The lookup port takes a virtual address and checks it against every entry. An entry can take part only if the tag it holds equals the current context register. Each entry masks the low address bits according to its own page size, so 4K, 16K, 512K and 8M pages can share the buffer. The answer appears one clock later. On a hit it gives the physical address, the protection group, the guarded bit and a size code. On a miss the page register is overwritten with the failed page, so the refill routine can read it back.

Top module: `soft_tlb`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses, and the control, page, segment and context registers all read as zero.
- R2: Registers are chosen by `regSel`, with these codes and fields:
  - 0, control: slot field in bits 12:8, reserve flag at bit 27.
  - 1, page: page number in bits 31:12, valid at bit 9, tag in bits 3:0.
  - 2, segment: protection group in bits 8:5, guarded at bit 4, size in bits 3:2, segment-valid at bit 0.
  - 3, real page: page number in bits 31:12, small-page select at bit 3. This register is write-only and reads as zero.
  - 4, context: tag in bits 3:0.
  Bits that are not listed read as zero.
- R3: A write to select 3 stores a new entry at the current slot field. The entry combines the written real page with the page and segment registers as they held before that clock edge. Lookups see the new entry from the next cycle on. A lookup made in the same cycle still sees the old contents.
- R4: One cycle after `lkValid` is high, exactly one of `lkHit` and `lkMiss` is high for one cycle. Both stay low in the cycle after a cycle without a request.
- R5: An entry matches only when its valid flag and its segment-valid flag are both set and its tag equals the context register.
- R6: Address bits are compared above the page boundary set by the entry's size: 31:12 for 4K, 31:14 for 16K, 31:19 for 512K and 31:23 for 8M.
  - Segment size 00 selects 4K or 16K, with small-page select 0 meaning 4K and 1 meaning 16K.
  - Size 01 selects 512K, size 11 selects 8M, and size 10 behaves like 00.
  - `lkSize` reports 0 for 4K, 1 for 16K, 2 for 512K and 3 for 8M.
- R7: On a hit, `lkPa` takes the real page bits above the page boundary and the virtual address bits below it, and `lkApg` and `lkGuarded` come from the entry. On a miss, every result output is zero.
- R8: When several entries match, the lowest-numbered one supplies the result and `lkMulti` is high.
- R9: At the edge where `lkMiss` rises, the page register is loaded with the missed address bits 31:12, valid 0 and the context tag. This load wins over a software write to the page register in the same cycle.
- R10: After each entry is stored, the slot field steps up by one and wraps from 31 to 0. While the reserve flag is set, any step that would land below 4 lands on 4 instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 3 | Register select code |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational on `regSel` |
| lkValid | input | 1 | Lookup request |
| lkVa | input | 32 | Lookup virtual address |
| lkHit | output | 1 | Lookup hit, one cycle after the request |
| lkMiss | output | 1 | Lookup miss, one cycle after the request |
| lkMulti | output | 1 | More than one entry matched |
| lkPa | output | 32 | Translated physical address |
| lkApg | output | 4 | Protection group of the winning entry |
| lkGuarded | output | 1 | Guarded bit of the winning entry |
| lkSize | output | 2 | Page size code of the winning entry |

## Verification
Two pairs of events can land in the same cycle.

The first pair is a commit and a lookup. The bench writes the real-page register while it looks up an address that only the new entry would cover. The lookup must miss, and the same address must hit one cycle later.

The second pair is a miss capture and a software write of the page register. The bench does both in one cycle, then reads the page register back. It must hold the missed page with valid clear, and not the value that was written.

// File: rtl/soft_tlb_pkg.sv
package soft_tlb_pkg;
  localparam int VA_W     = 32;
  localparam int PAGE_LSB = 12;
  localparam int PN_W     = VA_W - PAGE_LSB;
  localparam int ASID_W   = 4;
  localparam int APG_W    = 4;
  localparam int IDX_W    = 5;

  // bit positions of the register fields
  localparam int CTRL_IDX_LSB  = 8;
  localparam int CTRL_RSV_BIT  = 27;
  localparam int EPN_VALID_BIT = 9;
  localparam int SEG_APG_LSB   = 5;
  localparam int SEG_G_BIT     = 4;
  localparam int SEG_SIZE_LSB  = 2;
  localparam int SEG_VALID_BIT = 0;
  localparam int RPN_SMALL_BIT = 3;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_EPN  = 3'd1,
    SEL_SEG  = 3'd2,
    SEL_RPN  = 3'd3,
    SEL_CTX  = 3'd4
  } regSel_e;

  typedef struct packed {
    logic [PN_W-1:0]   epn;
    logic [ASID_W-1:0] asid;
    logic              eValid;
    logic [APG_W-1:0]  apg;
    logic              guarded;
    logic [1:0]        segSize;
    logic              sValid;
    logic              small16k;
    logic [PN_W-1:0]   rpn;
  } tlbEntry_t;

  typedef struct packed {
    logic             commit;
    logic [IDX_W-1:0] slot;
    tlbEntry_t        entry;
  } commitStrobe_t;

  // number of untranslated low address bits for a given size setting
  function automatic logic [4:0] pageShift(input logic [1:0] segSize, input logic small16k);
    case (segSize)
      2'b11:   return 5'd23;
      2'b01:   return 5'd19;
      default: return small16k ? 5'd14 : 5'd12;
    endcase
  endfunction

  function automatic logic [VA_W-1:0] pageMask(input logic [1:0] segSize, input logic small16k);
    logic [VA_W-1:0] one;
    one = 1;
    return ~((one << pageShift(segSize, small16k)) - one);
  endfunction

  function automatic logic [1:0] sizeCode(input logic [1:0] segSize, input logic small16k);
    case (segSize)
      2'b11:   return 2'd3;
      2'b01:   return 2'd2;
      default: return {1'b0, small16k};
    endcase
  endfunction
endpackage

// File: rtl/soft_tlb_ctrl.sv
module soft_tlb_ctrl
  import soft_tlb_pkg::*;
#(
  parameter int ENTRIES   = 32,
  parameter int RSV_SLOTS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regSel,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              missNow,
  input  logic [PN_W-1:0]   missPage,
  output logic [ASID_W-1:0] ctxAsid,
  output logic [31:0]       epnWord,
  output logic [IDX_W-1:0]  ctrlIdx,
  output logic              ctrlRsv,
  output commitStrobe_t     stb
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);
  localparam logic [IDX_W-1:0] RSV_IDX  = IDX_W'(RSV_SLOTS);

  regSel_e selE;
  assign selE = regSel_e'(regSel);

  logic [IDX_W-1:0]  idxQ;
  logic              rsvQ;
  logic [PN_W-1:0]   epnPageQ;
  logic              epnValidQ;
  logic [ASID_W-1:0] epnAsidQ;
  logic [APG_W-1:0]  apgQ;
  logic              guardQ;
  logic [1:0]        sizeQ;
  logic              segValidQ;
  logic [ASID_W-1:0] ctxQ;

  logic wrCtrl, wrEpn, wrSeg, wrRpn, wrCtx;
  assign wrCtrl = regWrEn && (selE == SEL_CTRL);
  assign wrEpn  = regWrEn && (selE == SEL_EPN);
  assign wrSeg  = regWrEn && (selE == SEL_SEG);
  assign wrRpn  = regWrEn && (selE == SEL_RPN);
  assign wrCtx  = regWrEn && (selE == SEL_CTX);

  function automatic logic [IDX_W-1:0] stepIdx(input logic [IDX_W-1:0] cur, input logic rsv);
    logic [IDX_W-1:0] nxt;
    nxt = (cur == LAST_IDX) ? '0 : cur + 1'b1;
    if (rsv && (nxt < RSV_IDX)) nxt = RSV_IDX;
    return nxt;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ <= '0;
      rsvQ <= 1'b0;
    end else if (wrCtrl) begin
      idxQ <= regWrData[CTRL_IDX_LSB +: IDX_W];
      rsvQ <= regWrData[CTRL_RSV_BIT];
    end else if (wrRpn) begin
      idxQ <= stepIdx(idxQ, rsvQ);
    end
  end

  // a miss capture wins over a software write of the page register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      epnPageQ  <= '0;
      epnValidQ <= 1'b0;
      epnAsidQ  <= '0;
    end else if (missNow) begin
      epnPageQ  <= missPage;
      epnValidQ <= 1'b0;
      epnAsidQ  <= ctxQ;
    end else if (wrEpn) begin
      epnPageQ  <= regWrData[31:PAGE_LSB];
      epnValidQ <= regWrData[EPN_VALID_BIT];
      epnAsidQ  <= regWrData[ASID_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      apgQ      <= '0;
      guardQ    <= 1'b0;
      sizeQ     <= '0;
      segValidQ <= 1'b0;
      ctxQ      <= '0;
    end else begin
      if (wrSeg) begin
        apgQ      <= regWrData[SEG_APG_LSB +: APG_W];
        guardQ    <= regWrData[SEG_G_BIT];
        sizeQ     <= regWrData[SEG_SIZE_LSB +: 2];
        segValidQ <= regWrData[SEG_VALID_BIT];
      end
      if (wrCtx) ctxQ <= regWrData[ASID_W-1:0];
    end
  end

  logic [31:0] ctrlWord, segWord;
  always_comb begin
    ctrlWord = '0;
    ctrlWord[CTRL_IDX_LSB +: IDX_W] = idxQ;
    ctrlWord[CTRL_RSV_BIT] = rsvQ;
    epnWord = '0;
    epnWord[31:PAGE_LSB] = epnPageQ;
    epnWord[EPN_VALID_BIT] = epnValidQ;
    epnWord[ASID_W-1:0] = epnAsidQ;
    segWord = '0;
    segWord[SEG_APG_LSB +: APG_W] = apgQ;
    segWord[SEG_G_BIT] = guardQ;
    segWord[SEG_SIZE_LSB +: 2] = sizeQ;
    segWord[SEG_VALID_BIT] = segValidQ;
  end

  always_comb begin
    case (selE)
      SEL_CTRL: regRdData = ctrlWord;
      SEL_EPN:  regRdData = epnWord;
      SEL_SEG:  regRdData = segWord;
      SEL_CTX:  regRdData = {{(32-ASID_W){1'b0}}, ctxQ};
      default:  regRdData = '0;
    endcase
  end

  always_comb begin
    stb.commit         = wrRpn;
    stb.slot           = idxQ;
    stb.entry.epn      = epnPageQ;
    stb.entry.asid     = epnAsidQ;
    stb.entry.eValid   = epnValidQ;
    stb.entry.apg      = apgQ;
    stb.entry.guarded  = guardQ;
    stb.entry.segSize  = sizeQ;
    stb.entry.sValid   = segValidQ;
    stb.entry.small16k = regWrData[RPN_SMALL_BIT];
    stb.entry.rpn      = regWrData[31:PAGE_LSB];
  end

  logic unusedWr;
  assign unusedWr = ^{regWrData[PAGE_LSB-1:EPN_VALID_BIT+1], regWrData[EPN_VALID_BIT-1:ASID_W]};

  assign ctxAsid = ctxQ;
  assign ctrlIdx = idxQ;
  assign ctrlRsv = rsvQ;
endmodule

// File: rtl/soft_tlb_dp.sv
module soft_tlb_dp
  import soft_tlb_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  commitStrobe_t     stb,
  input  logic [ASID_W-1:0] ctxAsid,
  input  logic              lkValid,
  input  logic [VA_W-1:0]   lkVa,
  output logic              anyHit,
  output logic              lkHit,
  output logic              lkMiss,
  output logic              lkMulti,
  output logic [VA_W-1:0]   lkPa,
  output logic [APG_W-1:0]  lkApg,
  output logic              lkGuarded,
  output logic [1:0]        lkSize
);
  localparam logic [IDX_W:0] ENT_LIM = (IDX_W+1)'(ENTRIES);

  tlbEntry_t          tblQ [ENTRIES];
  logic [ENTRIES-1:0] hitVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) tblQ[i] <= '0;
    end else if (stb.commit && ({1'b0, stb.slot} < ENT_LIM)) begin
      tblQ[stb.slot] <= stb.entry;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : gMatch
    logic [VA_W-1:0] cmpMask;
    assign cmpMask = pageMask(tblQ[g].segSize, tblQ[g].small16k);
    assign hitVec[g] = tblQ[g].eValid && tblQ[g].sValid && (tblQ[g].asid == ctxAsid)
                       && (((lkVa ^ {tblQ[g].epn, {PAGE_LSB{1'b0}}}) & cmpMask) == '0);
  end

  logic [IDX_W-1:0] winIdx;
  always_comb begin
    winIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) winIdx = IDX_W'(i);
    end
  end

  tlbEntry_t       winEnt;
  logic [VA_W-1:0] winMask, paNext;
  logic            multiNext;
  assign winEnt    = tblQ[winIdx];
  assign winMask   = pageMask(winEnt.segSize, winEnt.small16k);
  assign paNext    = ({winEnt.rpn, {PAGE_LSB{1'b0}}} & winMask) | (lkVa & ~winMask);
  assign anyHit    = |hitVec;
  assign multiNext = |(hitVec & (hitVec - 1'b1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lkHit <= 1'b0; lkMiss <= 1'b0; lkMulti <= 1'b0;
      lkPa <= '0; lkApg <= '0; lkGuarded <= 1'b0; lkSize <= '0;
    end else begin
      lkHit  <= lkValid && anyHit;
      lkMiss <= lkValid && !anyHit;
      if (lkValid && anyHit) begin
        lkMulti   <= multiNext;
        lkPa      <= paNext;
        lkApg     <= winEnt.apg;
        lkGuarded <= winEnt.guarded;
        lkSize    <= sizeCode(winEnt.segSize, winEnt.small16k);
      end else begin
        lkMulti <= 1'b0; lkPa <= '0; lkApg <= '0; lkGuarded <= 1'b0; lkSize <= '0;
      end
    end
  end
endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
  import soft_tlb_pkg::*;
#(
  parameter int ENTRIES   = 32,
  parameter int RSV_SLOTS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [2:0]  regSel,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        lkValid,
  input  logic [31:0] lkVa,
  output logic        lkHit,
  output logic        lkMiss,
  output logic        lkMulti,
  output logic [31:0] lkPa,
  output logic [3:0]  lkApg,
  output logic        lkGuarded,
  output logic [1:0]  lkSize
);
  commitStrobe_t     stb;
  logic [ASID_W-1:0] ctxAsid;
  logic [31:0]       epnWord;
  logic [IDX_W-1:0]  ctrlIdx;
  logic              ctrlRsv;
  logic              anyHit;
  logic              missNow;
  logic              commitEvt;

  assign missNow   = lkValid && !anyHit;
  assign commitEvt = stb.commit;

  soft_tlb_ctrl #(.ENTRIES(ENTRIES), .RSV_SLOTS(RSV_SLOTS)) i_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .regRdData(regRdData), .missNow(missNow), .missPage(lkVa[31:PAGE_LSB]),
    .ctxAsid(ctxAsid), .epnWord(epnWord), .ctrlIdx(ctrlIdx), .ctrlRsv(ctrlRsv), .stb(stb)
  );

  soft_tlb_dp #(.ENTRIES(ENTRIES)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .ctxAsid(ctxAsid), .lkValid(lkValid), .lkVa(lkVa),
    .anyHit(anyHit), .lkHit(lkHit), .lkMiss(lkMiss), .lkMulti(lkMulti), .lkPa(lkPa),
    .lkApg(lkApg), .lkGuarded(lkGuarded), .lkSize(lkSize)
  );
endmodule

// File: rtl/soft_tlb_chk.sv
module soft_tlb_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [2:0]  regSel,
  input logic        lkValid,
  input logic [31:0] lkVa,
  input logic        lkHit,
  input logic        lkMiss,
  input logic        lkMulti,
  input logic [31:0] lkPa,
  input logic [1:0]  lkSize,
  input logic [31:0] epnWord,
  input logic [4:0]  ctrlIdx,
  input logic        ctrlRsv,
  input logic        commitEvt
);
  p_hit_miss_excl_r4: assert property (@(posedge clk) disable iff (!rstN) !(lkHit && lkMiss));
  p_answer_r4: assert property (@(posedge clk) disable iff (!rstN) lkValid |=> (lkHit || lkMiss));
  p_quiet_r4: assert property (@(posedge clk) disable iff (!rstN) !lkValid |=> !(lkHit || lkMiss));
  p_multi_hit_r8: assert property (@(posedge clk) disable iff (!rstN) lkMulti |-> lkHit);
  p_pa_offset_r7: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> (lkPa[11:0] == $past(lkVa[11:0])));
  p_big_page_r6: assert property (@(posedge clk) disable iff (!rstN)
    (lkHit && lkSize == 2'd3) |-> (lkPa[22:0] == $past(lkVa[22:0])));
  p_miss_capture_r9: assert property (@(posedge clk) disable iff (!rstN)
    lkMiss |-> (epnWord[31:12] == $past(lkVa[31:12]) && !epnWord[9]));
  p_skip_reserved_r10: assert property (@(posedge clk) disable iff (!rstN)
    (commitEvt && ctrlRsv && !(regWrEn && regSel == 3'd0)) |=> (ctrlIdx >= 5'd4));
endmodule

bind soft_tlb soft_tlb_chk i_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .lkValid(lkValid),
  .lkVa(lkVa), .lkHit(lkHit), .lkMiss(lkMiss), .lkMulti(lkMulti), .lkPa(lkPa),
  .lkSize(lkSize), .epnWord(epnWord), .ctrlIdx(ctrlIdx), .ctrlRsv(ctrlRsv),
  .commitEvt(commitEvt)
);

// File: tb/test_soft_tlb.sv
module test_soft_tlb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [2:0] regSel = 3'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic lkValid = 1'b0;
  logic [31:0] lkVa = '0;
  logic lkHit, lkMiss, lkMulti, lkGuarded;
  logic [31:0] lkPa;
  logic [3:0] lkApg;
  logic [1:0] lkSize;

  always #2 clk = ~clk;

  soft_tlb i_soft_tlb (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .regRdData(regRdData), .lkValid(lkValid), .lkVa(lkVa), .lkHit(lkHit), .lkMiss(lkMiss),
    .lkMulti(lkMulti), .lkPa(lkPa), .lkApg(lkApg), .lkGuarded(lkGuarded), .lkSize(lkSize)
  );

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  // reference state, kept from the requirements
  logic [19:0] mEpn [32];
  logic [3:0]  mAsid [32];
  logic        mEv [32];
  logic [3:0]  mApg [32];
  logic        mG [32];
  logic [1:0]  mSeg [32];
  logic        mSv [32];
  logic        mSps [32];
  logic [19:0] mRpn [32];
  logic [4:0]  mIdx = '0;
  logic        mRsv = 1'b0;
  logic [19:0] rPage = '0;
  logic        rEv = 1'b0;
  logic [3:0]  rAsid = '0, rApg = '0, mCtx = '0;
  logic        rG = 1'b0, rSv = 1'b0;
  logic [1:0]  rSeg = '0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic modelLookup(input logic [31:0] va, output logic h, output logic mul,
                             output logic [31:0] pa, output logic [3:0] apg,
                             output logic g, output logic [1:0] sz);
    int cnt;
    int sh;
    logic [31:0] low;
    cnt = 0; h = 0; mul = 0; pa = 0; apg = 0; g = 0; sz = 0;
    for (int i = 0; i < 32; i++) begin
      sh = (mSeg[i] == 2'b11) ? 23 : (mSeg[i] == 2'b01) ? 19 : (mSps[i] ? 14 : 12);
      if (mEv[i] && mSv[i] && mAsid[i] == mCtx && ((va >> sh) == ({mEpn[i], 12'h0} >> sh))) begin
        cnt++;
        if (cnt == 1) begin
          low = (32'd1 << sh) - 1;
          pa = ({mRpn[i], 12'h0} & ~low) | (va & low);
          apg = mApg[i]; g = mG[i];
          sz = (sh == 23) ? 2'd3 : (sh == 19) ? 2'd2 : (sh == 14) ? 2'd1 : 2'd0;
        end
      end
    end
    h = (cnt > 0);
    mul = (cnt > 1);
  endtask

  task automatic step(input logic wr, input logic [2:0] sel, input logic [31:0] d,
                      input logic lv, input logic [31:0] va, input string req);
    logic eh, emul, eg;
    logic [31:0] epa;
    logic [3:0] eapg;
    logic [1:0] esz;
    logic [4:0] n;
    @(negedge clk);
    regWrEn = wr; regSel = sel; regWrData = d; lkValid = lv; lkVa = va;
    modelLookup(va, eh, emul, epa, eapg, eg, esz);
    if (!lv) begin eh = 0; emul = 0; epa = 0; eapg = 0; eg = 0; esz = 0; end
    // register model, using values before this edge
    if (wr && sel == 3'd3) begin
      mEpn[mIdx] = rPage; mAsid[mIdx] = rAsid; mEv[mIdx] = rEv; mApg[mIdx] = rApg;
      mG[mIdx] = rG; mSeg[mIdx] = rSeg; mSv[mIdx] = rSv; mSps[mIdx] = d[3]; mRpn[mIdx] = d[31:12];
      n = (mIdx == 5'd31) ? 5'd0 : mIdx + 5'd1;
      if (mRsv && n < 5'd4) n = 5'd4;
      mIdx = n;
    end
    if (wr && sel == 3'd0) begin mIdx = d[12:8]; mRsv = d[27]; end
    if (lv && !eh) begin rPage = va[31:12]; rEv = 0; rAsid = mCtx; end
    else if (wr && sel == 3'd1) begin rPage = d[31:12]; rEv = d[9]; rAsid = d[3:0]; end
    if (wr && sel == 3'd2) begin rApg = d[8:5]; rG = d[4]; rSeg = d[3:2]; rSv = d[0]; end
    if (wr && sel == 3'd4) mCtx = d[3:0];
    @(posedge clk);
    #1;
    chk(req, "lkHit", {31'h0, lkHit}, {31'h0, lv && eh});
    chk(req, "lkMiss", {31'h0, lkMiss}, {31'h0, lv && !eh});
    chk(req, "lkMulti", {31'h0, lkMulti}, {31'h0, emul});
    chk(req, "lkPa", lkPa, epa);
    chk(req, "lkApg", {28'h0, lkApg}, {28'h0, eapg});
    chk(req, "lkGuarded", {31'h0, lkGuarded}, {31'h0, eg});
    chk(req, "lkSize", {30'h0, lkSize}, {30'h0, esz});
    regWrEn = 0; lkValid = 0;
  endtask

  task automatic wrReg(input logic [2:0] sel, input logic [31:0] d, input string req);
    step(1'b1, sel, d, 1'b0, 32'h0, req);
  endtask

  task automatic look(input logic [31:0] va, input string req);
    step(1'b0, 3'd0, 32'h0, 1'b1, va, req);
  endtask

  task automatic readReg(input logic [2:0] sel, input string req);
    logic [31:0] exp;
    @(negedge clk);
    regWrEn = 0; regSel = sel;
    #1;
    case (sel)
      3'd0: exp = ({31'h0, mRsv} << 27) | ({27'h0, mIdx} << 8);
      3'd1: exp = {rPage, 12'h0} | ({31'h0, rEv} << 9) | {28'h0, rAsid};
      3'd2: exp = ({28'h0, rApg} << 5) | ({31'h0, rG} << 4) | ({30'h0, rSeg} << 2) | {31'h0, rSv};
      3'd4: exp = {28'h0, mCtx};
      default: exp = 32'h0;
    endcase
    chk(req, "regRdData", regRdData, exp);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      mEpn[i] = 0; mAsid[i] = 0; mEv[i] = 0; mApg[i] = 0; mG[i] = 0;
      mSeg[i] = 0; mSv[i] = 0; mSps[i] = 0; mRpn[i] = 0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int s = 0; s < 5; s++) readReg(3'(s), "R1");
    look(32'h0000_0ABC, "R1");

    // R2 field round trips, including unused bits
    wrReg(3'd2, 32'hFFFF_FFFF, "R2");
    readReg(3'd2, "R2");
    wrReg(3'd1, 32'hFFFF_FFFF, "R2");
    readReg(3'd1, "R2");
    wrReg(3'd0, 32'hFFFF_FFFF, "R2");
    readReg(3'd0, "R2");
    readReg(3'd3, "R2");

    // fill all slots through the stepping index: R3 R10
    wrReg(3'd4, 32'h5, "R2");
    readReg(3'd4, "R2");
    wrReg(3'd0, 32'h0, "R10");
    for (int i = 0; i < 32; i++) begin
      logic [1:0] sg;
      logic sp;
      sg = (i % 4 == 3) ? 2'b11 : (i % 4 == 2) ? 2'b01 : 2'b00;
      sp = (i % 4 == 1);
      if (i == 30) sg = 2'b10;
      wrReg(3'd1, (32'(i) << 23) | 32'h200 | 32'h5, "R3");
      wrReg(3'd2, (32'(i % 16) << 5) | (32'(i % 2) << 4) | (32'(sg) << 2) | 32'h1, "R3");
      wrReg(3'd3, {20'(i * 20'h1357 + 20'h00ABC), 12'h0} | (32'(sp) << 3), "R3");
    end
    readReg(3'd0, "R10");

    // sweep page sizes and offsets: R5 R6 R7
    for (int i = 0; i < 32; i++) begin
      look((32'(i) << 23) | 32'h0000_0ABC, "R6");
      look((32'(i) << 23) | 32'h0000_3FFC, "R6");
      look((32'(i) << 23) | 32'h0000_5004, "R6");
      look((32'(i) << 23) | 32'h0007_FFF0, "R7");
      look((32'(i) << 23) | 32'h007F_FFF8, "R7");
    end

    // context mismatch: R5
    wrReg(3'd4, 32'h6, "R5");
    look(32'h0180_0010, "R5");
    wrReg(3'd4, 32'h5, "R5");
    look(32'h0180_0010, "R5");

    // cleared valid flags: R5
    wrReg(3'd0, 32'h2 << 8, "R5");
    wrReg(3'd1, (32'd2 << 23) | 32'h5, "R5");
    wrReg(3'd2, 32'h1, "R5");
    wrReg(3'd3, 32'h0001_2000, "R5");
    look((32'd2 << 23) | 32'h10, "R5");
    wrReg(3'd1, (32'd3 << 23) | 32'h205, "R5");
    wrReg(3'd2, 32'hC, "R5");
    wrReg(3'd3, 32'h0003_4000, "R5");
    look((32'd3 << 23) | 32'h10, "R5");

    // overlapping entries: R8
    wrReg(3'd0, 32'h7 << 8, "R8");
    wrReg(3'd1, 32'h205, "R8");
    wrReg(3'd2, 32'h1ED, "R8");
    wrReg(3'd3, 32'hABC0_0000, "R8");
    look(32'h0000_0ABC, "R8");
    look(32'h0040_0ABC, "R8");

    // commit and lookup in one cycle: R3
    wrReg(3'd0, 32'hA << 8, "R3");
    wrReg(3'd1, (32'd40 << 23) | 32'h205, "R3");
    wrReg(3'd2, 32'h0D, "R3");
    step(1'b1, 3'd3, 32'h7770_0000, 1'b1, (32'd40 << 23) | 32'h123, "R3");
    look((32'd40 << 23) | 32'h123, "R3");

    // miss capture, alone and against a software write: R9
    look(32'hF000_1234, "R9");
    readReg(3'd1, "R9");
    step(1'b1, 3'd1, 32'h1111_1205, 1'b1, 32'hE000_5678, "R9");
    readReg(3'd1, "R9");

    // reserved slots: R10
    wrReg(3'd0, (32'd1 << 27) | (32'd31 << 8), "R10");
    wrReg(3'd3, 32'h0, "R10");
    readReg(3'd0, "R10");
    wrReg(3'd0, (32'd1 << 27) | (32'd1 << 8), "R10");
    wrReg(3'd3, 32'h0, "R10");
    readReg(3'd0, "R10");
    wrReg(3'd0, 32'd31 << 8, "R10");
    wrReg(3'd3, 32'h0, "R10");
    readReg(3'd0, "R10");

    repeat (2) @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule